// File: doc/BRIEF.md
# Vector Strip-Mining Length Sequencer

This block splits a vector operation over `n` elements into pieces that each fit a fixed maximum vector length (MVL). A one-cycle start pulse captures `n`. The block then hands out one descriptor per piece over a valid/ready handshake. Each descriptor carries the index of the first element of the piece and the length to load into a vector length register.

The short piece, `n mod MVL` elements long, is issued first. Every piece after it is a full MVL. When `n` is an exact multiple of MVL, including `n = 0`, the first piece has length zero. It is still issued, with an empty flag set, so the consumer always sees `floor(n/MVL) + 1` descriptors. A one-cycle done pulse follows the acceptance of the final descriptor.

The controller has three states:
- IDLE waits for start.
- EMIT presents descriptors.
- FINISH raises done for one cycle.

Its transitions are:
- start: IDLE to EMIT on a start pulse.
- advance: EMIT to EMIT when a descriptor that is not the last is accepted.
- complete: EMIT to FINISH when the last descriptor is accepted.
- retire: FINISH to IDLE, always after one cycle.

Top module: `strip_seq`

## Requirements
- R1: After reset, `desc_valid_o`, `busy_o` and `done_o` are all 0.
- R2: A `start_i` pulse sampled in IDLE makes `desc_valid_o` high in the next cycle. That first descriptor has `desc_start_o = 0` and `desc_len_o = n mod MVL`, where MVL is 64 by default.
- R3: Every descriptor after the first has `desc_len_o` equal to MVL.
- R4: Exactly `floor(n/MVL) + 1` descriptors are issued. `desc_last_o` is 1 on the final one and 0 on all the others.
- R5: The start index of each later descriptor equals the start index of the previous descriptor plus the previous descriptor's length.
- R6: When `n` is a nonzero multiple of MVL, the first descriptor has length 0 and `desc_empty_o = 1`. All later descriptors have `desc_empty_o = 0`.
- R7: For `n = 0` there is exactly one descriptor. It has length 0, with empty and last both set, and done follows it.
- R8: While `desc_valid_o` is 1 and `desc_ready_i` is 0, the descriptor fields stay unchanged and valid stays high.
- R9: `done_o` is high for exactly one cycle. That cycle is the one right after the last descriptor is accepted, and `desc_valid_o` is 0 during it.
- R10: A `start_i` pulse while `busy_o` is 1 is ignored. This holds in EMIT and also in the done cycle; the sequence in progress continues unchanged, and no new run begins.
- R11: `busy_o` is 1 from the cycle after an accepted start through the done cycle, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; samples `n_i` when idle |
| n_i | input | N_W | Total element count |
| desc_ready_i | input | 1 | Consumer accepts the current descriptor |
| desc_valid_o | output | 1 | A descriptor is presented |
| desc_start_o | output | N_W | Index of the first element of this piece |
| desc_len_o | output | MVL_LOG2+1 | Vector length for this piece |
| desc_empty_o | output | 1 | This piece has length zero |
| desc_last_o | output | 1 | This is the final piece |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse after the final acceptance |

## Verification
The timing of each result is as follows:
- The first descriptor is due one clock edge after the edge that samples `start_i`.
- Each later descriptor is due one edge after the accepting edge.
- `done_o` is due one edge after the final acceptance and falls on the next edge.

The bench drives its inputs 1 ns after a rising edge and reads the outputs at that same moment, so every check looks at the state left by exactly one edge. Stall cases hold ready low for one extra edge and then re-read the unchanged fields before accepting.

// File: rtl/strip_pkg.sv
package strip_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EMIT   = 2'd1,
        ST_FINISH = 2'd2
    } strip_state_e;

endpackage

// File: rtl/strip_split.sv
// Derives the length of the leading (short) piece and the number of pieces
// from the element count. MVL is a power of two, so modulo is a low slice
// and the quotient is the remaining high bits.
module strip_split #(
    parameter int N_W      = 16,
    parameter int MVL_LOG2 = 6,
    localparam int VL_W    = MVL_LOG2 + 1,
    localparam int CNT_W   = N_W - MVL_LOG2 + 1
) (
    input  logic [N_W-1:0]   n_i,
    output logic [VL_W-1:0]  first_len_o,
    output logic [CNT_W-1:0] chunk_cnt_o
);

    logic [CNT_W-1:0] quot;

    generate
        if (MVL_LOG2 == 0) begin : g_unit
            assign first_len_o = '0;
            assign quot        = CNT_W'(n_i);
        end else begin : g_pow2
            assign first_len_o = {1'b0, n_i[MVL_LOG2-1:0]};
            assign quot        = {1'b0, n_i[N_W-1:MVL_LOG2]};
        end
    endgenerate

    assign chunk_cnt_o = quot + CNT_W'(1);

endmodule

// File: rtl/strip_cursor.sv
// Holds the descriptor under presentation: start index, length and the
// number of pieces still to hand out (including the current one).
module strip_cursor #(
    parameter int N_W      = 16,
    parameter int MVL_LOG2 = 6,
    localparam int VL_W    = MVL_LOG2 + 1,
    localparam int CNT_W   = N_W - MVL_LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [VL_W-1:0]  first_len_i,
    input  logic [CNT_W-1:0] chunk_cnt_i,
    output logic [N_W-1:0]   start_o,
    output logic [VL_W-1:0]  len_o,
    output logic             last_o
);

    localparam logic [VL_W-1:0] FULL_LEN = VL_W'(1) << MVL_LOG2;

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o <= '0;
            len_o   <= '0;
            left_q  <= '0;
        end else if (load_i) begin
            start_o <= '0;
            len_o   <= first_len_i;
            left_q  <= chunk_cnt_i;
        end else if (step_i) begin
            start_o <= start_o + N_W'(len_o);
            len_o   <= FULL_LEN;
            left_q  <= left_q - CNT_W'(1);
        end
    end

    assign last_o = (left_q == CNT_W'(1));

endmodule

// File: rtl/strip_ctrl.sv
// Sequencing state machine: IDLE -> EMIT (start), EMIT -> EMIT (advance),
// EMIT -> FINISH (complete), FINISH -> IDLE (retire).
module strip_ctrl
    import strip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ready_i,
    input  logic last_i,
    output logic load_o,
    output logic step_o,
    output logic valid_o,
    output logic busy_o,
    output logic done_o
);

    strip_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (ready_i && last_i) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        load_o  = 1'b0;
        step_o  = 1'b0;
        valid_o = 1'b0;
        busy_o  = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_o = start_i;
            end
            ST_EMIT: begin
                valid_o = 1'b1;
                busy_o  = 1'b1;
                step_o  = ready_i && !last_i;
            end
            ST_FINISH: begin
                busy_o = 1'b1;
                done_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/strip_seq.sv
module strip_seq #(
    parameter int N_W      = 16,
    parameter int MVL_LOG2 = 6,
    localparam int VL_W    = MVL_LOG2 + 1,
    localparam int CNT_W   = N_W - MVL_LOG2 + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [N_W-1:0]  n_i,
    input  logic            desc_ready_i,
    output logic            desc_valid_o,
    output logic [N_W-1:0]  desc_start_o,
    output logic [VL_W-1:0] desc_len_o,
    output logic            desc_empty_o,
    output logic            desc_last_o,
    output logic            busy_o,
    output logic            done_o
);

    logic [VL_W-1:0]  first_len;
    logic [CNT_W-1:0] chunk_cnt;
    logic             load, step, last;

    strip_split #(.N_W(N_W), .MVL_LOG2(MVL_LOG2)) u_split (
        .n_i         (n_i),
        .first_len_o (first_len),
        .chunk_cnt_o (chunk_cnt)
    );

    strip_cursor #(.N_W(N_W), .MVL_LOG2(MVL_LOG2)) u_cursor (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .step_i      (step),
        .first_len_i (first_len),
        .chunk_cnt_i (chunk_cnt),
        .start_o     (desc_start_o),
        .len_o       (desc_len_o),
        .last_o      (last)
    );

    strip_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .ready_i (desc_ready_i),
        .last_i  (last),
        .load_o  (load),
        .step_o  (step),
        .valid_o (desc_valid_o),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    assign desc_last_o  = last;
    assign desc_empty_o = (desc_len_o == '0);

endmodule

// File: rtl/strip_seq_chk.sv
module strip_seq_chk #(
    parameter int N_W      = 16,
    parameter int MVL_LOG2 = 6,
    localparam int VL_W    = MVL_LOG2 + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            desc_ready_i,
    input logic            desc_valid_o,
    input logic [N_W-1:0]  desc_start_o,
    input logic [VL_W-1:0] desc_len_o,
    input logic            desc_empty_o,
    input logic            desc_last_o,
    input logic            busy_o,
    input logic            done_o
);

    localparam logic [VL_W-1:0] FULL_LEN = VL_W'(1) << MVL_LOG2;

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o && !desc_ready_i |=> desc_valid_o && $stable(desc_start_o)
            && $stable(desc_len_o) && $stable(desc_last_o));

    assert_full_after_R3: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o && desc_ready_i && !desc_last_o |=> desc_valid_o && desc_len_o == FULL_LEN);

    assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o && desc_ready_i && !desc_last_o |=>
            desc_start_o == $past(desc_start_o) + N_W'($past(desc_len_o)));

    assert_empty_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o && desc_empty_o |-> desc_start_o == '0);

    assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o && desc_ready_i && desc_last_o |=> done_o && !desc_valid_o);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    assert_busy_cover_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid_o || done_o) |-> busy_o);

endmodule

bind strip_seq strip_seq_chk #(.N_W(N_W), .MVL_LOG2(MVL_LOG2)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .desc_ready_i (desc_ready_i),
    .desc_valid_o (desc_valid_o),
    .desc_start_o (desc_start_o),
    .desc_len_o   (desc_len_o),
    .desc_empty_o (desc_empty_o),
    .desc_last_o  (desc_last_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/strip_seq_test.sv
`timescale 1ns/1ps
module strip_seq_test;

    localparam int N_W = 16;
    localparam int LG  = 6;
    localparam int MVL = 1 << LG;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [N_W-1:0]  n_i = '0;
    logic            desc_ready_i = 1'b0;
    logic            desc_valid_o;
    logic [N_W-1:0]  desc_start_o;
    logic [LG:0]     desc_len_o;
    logic            desc_empty_o;
    logic            desc_last_o;
    logic            busy_o;
    logic            done_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    strip_seq #(.N_W(N_W), .MVL_LOG2(LG)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .n_i(n_i),
        .desc_ready_i(desc_ready_i), .desc_valid_o(desc_valid_o),
        .desc_start_o(desc_start_o), .desc_len_o(desc_len_o),
        .desc_empty_o(desc_empty_o), .desc_last_o(desc_last_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Runs one full sequence for n. stall: hold ready low one cycle per
    // descriptor. poke: pulse start with another n while busy (R10).
    task automatic run_case(input int n, input bit stall, input bit poke);
        int chunks = n / MVL + 1;
        int st = 0;
        tick();
        start_i = 1'b1;
        n_i = N_W'(n);
        tick();
        start_i = 1'b0;
        n_i = '0;
        for (int k = 0; k < chunks; k++) begin
            int len = (k == 0) ? (n % MVL) : MVL;
            bit lst = (k == chunks - 1);
            chk(desc_valid_o == 1'b1, (k == 0) ? "R2" : "R4", int'(desc_valid_o), 1);
            chk(busy_o == 1'b1, "R11", int'(busy_o), 1);
            chk(int'(desc_start_o) == st, (k == 0) ? "R2" : "R5", int'(desc_start_o), st);
            chk(int'(desc_len_o) == len, (k == 0) ? "R2" : "R3", int'(desc_len_o), len);
            chk(desc_last_o == lst, "R4", int'(desc_last_o), int'(lst));
            chk(desc_empty_o == (len == 0), "R6", int'(desc_empty_o), int'(len == 0));
            if (stall || (poke && k == 0)) begin
                desc_ready_i = 1'b0;
                if (poke && k == 0) begin
                    start_i = 1'b1;
                    n_i = N_W'(5);
                end
                tick();
                start_i = 1'b0;
                n_i = '0;
                chk(desc_valid_o == 1'b1, "R8", int'(desc_valid_o), 1);
                chk(int'(desc_start_o) == st, poke ? "R10" : "R8", int'(desc_start_o), st);
                chk(int'(desc_len_o) == len, poke ? "R10" : "R8", int'(desc_len_o), len);
            end
            desc_ready_i = 1'b1;
            tick();
            desc_ready_i = 1'b0;
            st += len;
        end
        chk(done_o == 1'b1, "R9", int'(done_o), 1);
        chk(desc_valid_o == 1'b0, "R9", int'(desc_valid_o), 0);
        chk(busy_o == 1'b1, "R11", int'(busy_o), 1);
        if (poke) begin
            start_i = 1'b1;
            n_i = N_W'(7);
        end
        tick();
        start_i = 1'b0;
        n_i = '0;
        chk(done_o == 1'b0, "R9", int'(done_o), 0);
        chk(busy_o == 1'b0, "R11", int'(busy_o), 0);
        if (poke) begin
            tick();
            chk(desc_valid_o == 1'b0, "R10", int'(desc_valid_o), 0);
            chk(busy_o == 1'b0, "R10", int'(busy_o), 0);
        end
    endtask

    task automatic test_reset();
        tick();
        tick();
        chk(desc_valid_o == 1'b0, "R1", int'(desc_valid_o), 0);
        chk(busy_o == 1'b0, "R1", int'(busy_o), 0);
        chk(done_o == 1'b0, "R1", int'(done_o), 0);
        rst_n = 1'b1;
        tick();
        chk(desc_valid_o == 1'b0, "R1", int'(desc_valid_o), 0);
    endtask

    initial begin
        test_reset();
        run_case(10, 1'b0, 1'b0);      // R2 single short piece
        run_case(200, 1'b0, 1'b0);     // R3 R4 R5: 8 then 64 x3
        run_case(128, 1'b0, 1'b0);     // R6 exact multiple
        run_case(0, 1'b0, 1'b0);       // R7 zero count
        run_case(75, 1'b1, 1'b0);      // R8 stalls
        run_case(130, 1'b0, 1'b1);     // R10 start while busy
        run_case(64, 1'b1, 1'b0);      // R6 R8 combined
        run_case(1000, 1'b0, 1'b0);    // R4 longer run
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule